// File: doc/BRIEF.md
# Dual-Lane Slave Serial Audio Port

This block is a four-channel serial audio port built to the common I2S framing. The receive side takes two serial data lanes that share one bit clock and one word select. Lane front carries the front left/right pair and lane rear carries the rear pair. Once the right channel of a frame has ended, the block presents all four samples in parallel and raises a single-cycle strobe. The transmit side works the other way. It takes four parallel samples and shifts them out on two serial lanes, timed by a second bit clock and word select that have no fixed relation to the receive pair.

The port is a slave in both directions: every bit clock and word select comes from outside. All serial inputs pass through a synchroniser into one system clock domain, and every output is registered there. The system clock must run well above the bit clocks, so that each bit-clock half period lasts several system cycles. Internally every sample is 20 bits wide. A longer serial word loses its extra low bits. A shorter one is filled with zeros below its last received bit.

Top module: `dual_lane_i2s_port`

## Requirements
- R1: On receive, the word sent while word select is 0 appears on the left outputs, and the word sent while word select is 1 appears on the right outputs.
- R2: On receive, the first bit of a channel word is the bit sampled on the second rising bit-clock edge at which the new word-select level is seen. The bit taken on the first such edge belongs to the previous word.
- R3: Received bits are sampled on the rising bit-clock edge and are taken MSB first. Output bit 19 holds the first bit of the word, so the sign of a two's-complement sample is kept.
- R4: A received word shorter than 20 bits fills the top output bits, and the low bits it does not reach read 0. For a 16-bit word, bits 3..0 are 0.
- R5: A received word longer than 20 bits keeps its first 20 bits, and the later bits change nothing at the outputs.
- R6: Each frame gives four samples: front lane left/right on rx_front_l and rx_front_r, and rear lane left/right on rx_rear_l and rx_rear_r. These outputs change only in the cycle in which rx_valid is high.
- R7: rx_valid is high for exactly one system cycle per complete frame, after the right words of both lanes end. A frame whose left word began before the first word-select transition seen after reset produces no pulse.
- R8: On transmit, each lane changes its serial output only after a falling edge of tx_bclk. The MSB of a channel goes out on the falling edge that follows the rising edge at which the new word-select level is first seen. Word select 0 sends the left sample and 1 sends the right sample, MSB first.
- R9: The four transmit inputs are latched once per frame, at the start of the left channel. Input changes made during a frame do not reach the serial lanes before the next frame.
- R10: In a transmit slot longer than 20 bits, every bit position after the 20th is driven 0.
- R11: The receive and transmit sides run at the same time, from unrelated bit clocks, without disturbing each other.
- R12: After reset, all received samples are 0, rx_valid is 0, and both transmit lanes drive 0 until the first word-select transition on the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bclk | input | 1 | Receive bit clock from the external master |
| rx_ws | input | 1 | Receive word select (0 = left, 1 = right) |
| rx_sd_front | input | 1 | Receive serial data, front lane |
| rx_sd_rear | input | 1 | Receive serial data, rear lane |
| rx_front_l | output | 20 | Received front left sample |
| rx_front_r | output | 20 | Received front right sample |
| rx_rear_l | output | 20 | Received rear left sample |
| rx_rear_r | output | 20 | Received rear right sample |
| rx_valid | output | 1 | One-cycle strobe when a new frame of four samples is presented |
| tx_bclk | input | 1 | Transmit bit clock from the external master |
| tx_ws | input | 1 | Transmit word select (0 = left, 1 = right) |
| tx_front_l | input | 20 | Front left sample to send |
| tx_front_r | input | 20 | Front right sample to send |
| tx_rear_l | input | 20 | Rear left sample to send |
| tx_rear_r | input | 20 | Rear right sample to send |
| tx_sd_front | output | 1 | Transmit serial data, front lane |
| tx_sd_rear | output | 1 | Transmit serial data, rear lane |

## Verification
The assertions watch properties that hold in every cycle:
- rx_valid lasts one cycle and always follows a synchronised rising bit-clock edge.
- The received samples stay unchanged while no strobe is present.
- The transmit lanes change only after a falling edge is detected.
- The transmit lanes stay at 0 until the transmit side has locked to word select.

The values themselves can only be shown by the bench scenarios. These cover zero padding of 16-bit words and truncation of 24-bit words, the left/right and front/rear mapping, and the number of pulses per run. They also cover latching of the transmit inputs once per frame, the zero tail in 24-bit transmit slots, and both directions running at once from unrelated clocks.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_edge_sync.sv
// Brings an external serial clock and its data bits into the system domain
// and flags its rising and falling edges. Data is aligned with the edge flags.
module i2s_edge_sync #(
  parameter int DATA_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic [DATA_W-1:0] ser_data,
  output logic              rise,
  output logic              fall,
  output logic [DATA_W-1:0] data_q
);
  logic [STAGES-1:0] clk_pipe;
  logic              clk_last;
  logic [DATA_W-1:0] data_pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      clk_last <= 1'b0;
      for (int i = 0; i < STAGES; i++) data_pipe[i] <= '0;
    end else begin
      clk_pipe     <= {clk_pipe[STAGES-2:0], ser_clk};
      clk_last     <= clk_pipe[STAGES-1];
      data_pipe[0] <= ser_data;
      for (int i = 1; i < STAGES; i++) data_pipe[i] <= data_pipe[i-1];
    end
  end

  assign rise   = clk_pipe[STAGES-1] & ~clk_last;
  assign fall   = ~clk_pipe[STAGES-1] & clk_last;
  assign data_q = data_pipe[STAGES-1];
endmodule

// File: rtl/i2s_rx_lane.sv
// Deserialises one data lane. Bits land MSB first; bits past SAMPLE_W are
// dropped and positions never reached stay zero.
module i2s_rx_lane
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                bit_in,
  input  logic                word_end,
  input  chan_e               end_chan,
  output logic [SAMPLE_W-1:0] left_hold,
  output logic [SAMPLE_W-1:0] word_now
);
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]    CNT_MAX = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg;
  logic [CNT_W-1:0]    cnt;

  // current word including the bit on the line this cycle
  always_comb word_now = shreg | (bit_in ? (TOP_BIT >> cnt) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      left_hold <= '0;
    end else if (bit_stb) begin
      if (word_end) begin
        shreg <= '0;
        cnt   <= '0;
        if (end_chan == CH_LEFT) left_hold <= word_now;
      end else begin
        shreg <= word_now;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_tx_lane.sv
// Serialises one lane: holds a left/right pair latched at frame start and
// drives one bit per falling edge, zero beyond SAMPLE_W.
module i2s_tx_lane
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift,
  input  chan_e               chan,
  input  logic [CNT_W-1:0]    idx,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sd
);
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] left_lat, right_lat, cur;
  logic                bit_val;

  always_comb begin
    cur     = (chan == CH_LEFT) ? left_lat : right_lat;
    bit_val = |(cur & (TOP_BIT >> idx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_lat  <= '0;
      right_lat <= '0;
      sd        <= 1'b0;
    end else begin
      if (load) begin
        left_lat  <= left_in;
        right_lat <= right_in;
      end
      if (shift) sd <= bit_val;
    end
  end
endmodule

// File: rtl/dual_lane_i2s_port.sv
module dual_lane_i2s_port
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bclk,
  input  logic                rx_ws,
  input  logic                rx_sd_front,
  input  logic                rx_sd_rear,
  output logic [SAMPLE_W-1:0] rx_front_l,
  output logic [SAMPLE_W-1:0] rx_front_r,
  output logic [SAMPLE_W-1:0] rx_rear_l,
  output logic [SAMPLE_W-1:0] rx_rear_r,
  output logic                rx_valid,
  input  logic                tx_bclk,
  input  logic                tx_ws,
  input  logic [SAMPLE_W-1:0] tx_front_l,
  input  logic [SAMPLE_W-1:0] tx_front_r,
  input  logic [SAMPLE_W-1:0] tx_rear_l,
  input  logic [SAMPLE_W-1:0] tx_rear_r,
  output logic                tx_sd_front,
  output logic                tx_sd_rear
);
  localparam int LANES = 2;
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMPLE_W);

  // ---------------- receive ----------------
  logic             rx_rise, rx_fall_unused;
  logic [LANES:0]   rx_bits;   // {ws, rear, front}
  logic             rx_ws_now, rx_ws_prev, rx_have_prev, rx_locked, rx_left_seen;
  logic             rx_change, rx_frame_end;
  logic [LANES-1:0] rx_sd_sync;
  logic [SAMPLE_W-1:0] lane_left [LANES];
  logic [SAMPLE_W-1:0] lane_now  [LANES];

  i2s_edge_sync #(.DATA_W(LANES + 1), .STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk), .rst(rst), .ser_clk(rx_bclk),
    .ser_data({rx_ws, rx_sd_rear, rx_sd_front}),
    .rise(rx_rise), .fall(rx_fall_unused), .data_q(rx_bits)
  );

  assign rx_ws_now  = rx_bits[LANES];
  assign rx_sd_sync = rx_bits[LANES-1:0];

  always_comb begin
    rx_change    = rx_have_prev && (rx_ws_now != rx_ws_prev);
    rx_frame_end = rx_rise && rx_change && (rx_ws_prev == CH_RIGHT) && rx_left_seen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ws_prev   <= 1'b0;
      rx_have_prev <= 1'b0;
      rx_locked    <= 1'b0;
      rx_left_seen <= 1'b0;
    end else if (rx_rise) begin
      rx_ws_prev   <= rx_ws_now;
      rx_have_prev <= 1'b1;
      if (rx_change) begin
        rx_locked <= 1'b1;
        if (rx_ws_prev == CH_LEFT && rx_locked) rx_left_seen <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rx
    i2s_rx_lane #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst),
      .bit_stb(rx_rise), .bit_in(rx_sd_sync[g]),
      .word_end(rx_change), .end_chan(chan_e'(rx_ws_prev)),
      .left_hold(lane_left[g]), .word_now(lane_now[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_front_l <= '0;
      rx_front_r <= '0;
      rx_rear_l  <= '0;
      rx_rear_r  <= '0;
      rx_valid   <= 1'b0;
    end else begin
      rx_valid <= rx_frame_end;
      if (rx_frame_end) begin
        rx_front_l <= lane_left[0];
        rx_front_r <= lane_now[0];
        rx_rear_l  <= lane_left[1];
        rx_rear_r  <= lane_now[1];
      end
    end
  end

  // ---------------- transmit ----------------
  logic             tx_rise, tx_fall;
  logic [0:0]       tx_ws_sync;
  logic             tx_ws_prev, tx_have_prev, tx_locked, tx_change, tx_load;
  chan_e            tx_chan;
  logic [CNT_W-1:0] tx_idx;
  logic [SAMPLE_W-1:0] tx_left  [LANES];
  logic [SAMPLE_W-1:0] tx_right [LANES];
  logic [LANES-1:0] tx_sd;

  i2s_edge_sync #(.DATA_W(1), .STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk), .rst(rst), .ser_clk(tx_bclk), .ser_data(tx_ws),
    .rise(tx_rise), .fall(tx_fall), .data_q(tx_ws_sync)
  );

  always_comb begin
    tx_change = tx_have_prev && (tx_ws_sync[0] != tx_ws_prev);
    tx_load   = tx_rise && tx_change && (tx_ws_sync[0] == CH_LEFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ws_prev   <= 1'b0;
      tx_have_prev <= 1'b0;
      tx_locked    <= 1'b0;
      tx_chan      <= CH_LEFT;
      tx_idx       <= '0;
    end else if (tx_rise) begin
      tx_ws_prev   <= tx_ws_sync[0];
      tx_have_prev <= 1'b1;
      if (tx_change) begin
        tx_locked <= 1'b1;
        tx_chan   <= chan_e'(tx_ws_sync[0]);
        tx_idx    <= '0;
      end
    end else if (tx_fall && tx_locked && tx_idx != CNT_MAX) begin
      tx_idx <= tx_idx + 1'b1;
    end
  end

  assign tx_left[0]  = tx_front_l;
  assign tx_right[0] = tx_front_r;
  assign tx_left[1]  = tx_rear_l;
  assign tx_right[1] = tx_rear_r;

  for (genvar g = 0; g < LANES; g++) begin : g_tx
    i2s_tx_lane #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst),
      .load(tx_load), .shift(tx_fall && tx_locked),
      .chan(tx_chan), .idx(tx_idx),
      .left_in(tx_left[g]), .right_in(tx_right[g]),
      .sd(tx_sd[g])
    );
  end

  assign tx_sd_front = tx_sd[0];
  assign tx_sd_rear  = tx_sd[1];
endmodule

// File: rtl/i2s_port_checker.sv
module i2s_port_checker #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                rx_rise,
  input logic                rx_valid,
  input logic [SAMPLE_W-1:0] rx_front_l,
  input logic [SAMPLE_W-1:0] rx_front_r,
  input logic [SAMPLE_W-1:0] rx_rear_l,
  input logic [SAMPLE_W-1:0] rx_rear_r,
  input logic                tx_fall,
  input logic                tx_locked,
  input logic                tx_sd_front,
  input logic                tx_sd_rear
);
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_valid_after_edge_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rx_rise));

  assert_samples_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_front_l) && $stable(rx_front_r) &&
                   $stable(rx_rear_l) && $stable(rx_rear_r)));

  assert_tx_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !tx_fall |=> ($stable(tx_sd_front) && $stable(tx_sd_rear)));

  assert_tx_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !tx_locked |-> (!tx_sd_front && !tx_sd_rear));
endmodule

bind dual_lane_i2s_port i2s_port_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .rx_rise(rx_rise), .rx_valid(rx_valid),
  .rx_front_l(rx_front_l), .rx_front_r(rx_front_r),
  .rx_rear_l(rx_rear_l), .rx_rear_r(rx_rear_r),
  .tx_fall(tx_fall), .tx_locked(tx_locked),
  .tx_sd_front(tx_sd_front), .tx_sd_rear(tx_sd_rear)
);

// File: tb/sim_dual_lane_i2s_port.sv
module sim_dual_lane_i2s_port;
  localparam int CLK_PERIOD = 10;
  localparam int RX_H = 8;
  localparam int TX_H = 11;
  localparam int NF = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_bclk = 1'b1, rx_ws = 1'b1, rx_sd_front = 1'b0, rx_sd_rear = 1'b0;
  logic tx_bclk = 1'b1, tx_ws = 1'b1;
  logic [19:0] tx_front_l = '0, tx_front_r = '0, tx_rear_l = '0, tx_rear_r = '0;
  logic [19:0] rx_front_l, rx_front_r, rx_rear_l, rx_rear_r;
  logic rx_valid, tx_sd_front, tx_sd_rear;

  int n_checks = 0, n_fail = 0, vcount = 0;
  bit done = 0;
  logic [19:0] cap [8][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_i2s_port u0 (
    .clk(clk), .rst(rst),
    .rx_bclk(rx_bclk), .rx_ws(rx_ws), .rx_sd_front(rx_sd_front), .rx_sd_rear(rx_sd_rear),
    .rx_front_l(rx_front_l), .rx_front_r(rx_front_r), .rx_rear_l(rx_rear_l), .rx_rear_r(rx_rear_r),
    .rx_valid(rx_valid),
    .tx_bclk(tx_bclk), .tx_ws(tx_ws),
    .tx_front_l(tx_front_l), .tx_front_r(tx_front_r), .tx_rear_l(tx_rear_l), .tx_rear_r(tx_rear_r),
    .tx_sd_front(tx_sd_front), .tx_sd_rear(tx_sd_rear)
  );

  always @(negedge clk) begin
    if (rst) vcount <= 0;
    else if (rx_valid) begin
      if (vcount < 8) begin
        cap[vcount][0] <= rx_front_l;
        cap[vcount][1] <= rx_front_r;
        cap[vcount][2] <= rx_rear_l;
        cap[vcount][3] <= rx_rear_r;
      end
      vcount <= vcount + 1;
    end
  end

  // channel index: 0 front L, 1 front R, 2 rear L, 3 rear R
  function automatic logic [23:0] pat(int f, int c);
    logic [31:0] t;
    case (f)
      0: return 24'hFFFFFF;
      1: return c[0] ? 24'h800000 : 24'h7FFFFF;
      2: return (c < 2) ? 24'h000001 : 24'hC0000F;
      default: begin
        t = f * 32'h0013_579B + c * 32'h002A_C3D5 + 32'h0055_AA11;
        return t[23:0];
      end
    endcase
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_bclk = 1'b1; rx_ws = 1'b1; rx_sd_front = 1'b0; rx_sd_rear = 1'b0;
    tx_bclk = 1'b1; tx_ws = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 rx_valid", {23'd0, rx_valid}, 24'd0);
    check("R12 rx samples", {4'd0, rx_front_l | rx_front_r | rx_rear_l | rx_rear_r}, 24'd0);
    check("R12 tx lanes", {22'd0, tx_sd_rear, tx_sd_front}, 24'd0);
  endtask

  task automatic rx_bit(logic ws, logic d0, logic d1);
    rx_bclk = 1'b0; rx_ws = ws; rx_sd_front = d0; rx_sd_rear = d1;
    repeat (RX_H) @(negedge clk);
    rx_bclk = 1'b1;
    repeat (RX_H) @(negedge clk);
  endtask

  task automatic rx_stream(int n);
    logic [23:0] v0, v1;
    for (int i = 0; i < n; i++) rx_bit((i == n-1) ? 1'b0 : 1'b1, 1'b0, 1'b0);
    for (int f = 0; f < NF; f++)
      for (int ch = 0; ch < 2; ch++) begin
        v0 = pat(f, ch);
        v1 = pat(f, ch + 2);
        for (int i = 0; i < n; i++)
          rx_bit((ch == 0) ? (i == n-1) : (i != n-1), v0[23-i], v1[23-i]);
      end
    for (int i = 0; i < 4; i++) rx_bit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic tx_bit(logic ws, output logic s0, output logic s1);
    tx_bclk = 1'b0; tx_ws = ws;
    repeat (TX_H) @(negedge clk);
    s0 = tx_sd_front; s1 = tx_sd_rear;
    tx_bclk = 1'b1;
    repeat (TX_H) @(negedge clk);
  endtask

  task automatic tx_set(int f);
    logic [23:0] a, b, c, d;
    a = pat(f, 0); b = pat(f, 1); c = pat(f, 2); d = pat(f, 3);
    tx_front_l = a[23:4]; tx_front_r = b[23:4];
    tx_rear_l  = c[23:4]; tx_rear_r  = d[23:4];
  endtask

  task automatic tx_stream(int n);
    logic s0, s1;
    logic [23:0] g0, g1, e0, e1, p0, p1;
    string req;
    tx_set(0);
    for (int i = 0; i < n; i++) tx_bit((i == n-1) ? 1'b0 : 1'b1, s0, s1);
    for (int f = 0; f < NF; f++)
      for (int ch = 0; ch < 2; ch++) begin
        g0 = '0; g1 = '0;
        for (int i = 0; i < n; i++) begin
          tx_bit((ch == 0) ? (i == n-1) : (i != n-1), s0, s1);
          g0[23-i] = s0; g1[23-i] = s1;
          if (ch == 0 && i == 2 && f + 1 < NF) tx_set(f + 1);
        end
        p0 = pat(f, ch); p1 = pat(f, ch + 2);
        e0 = {p0[23:4], 4'd0} & ~(24'hFFFFFF >> n);
        e1 = {p1[23:4], 4'd0} & ~(24'hFFFFFF >> n);
        if (n == 24) req = "R10 tx zero tail";
        else if (n == 16) req = "R11 tx concurrent with rx";
        else if (f == 0) req = "R8 tx MSB first";
        else req = "R9 tx latched per frame";
        check($sformatf("%s n=%0d f=%0d ch=%0d front", req, n, f, ch), g0, e0);
        check($sformatf("%s n=%0d f=%0d ch=%0d rear", req, n, f, ch), g1, e1);
      end
  endtask

  task automatic run_len(int n);
    logic [23:0] v;
    logic [19:0] m;
    string req;
    do_reset();
    fork
      rx_stream(n);
      tx_stream(n);
    join
    repeat (4) @(negedge clk);
    check($sformatf("R7 frame pulses n=%0d", n), 24'(vcount), 24'(NF));
    m = ~(20'hFFFFF >> n);
    for (int f = 0; f < NF && f < 8; f++)
      for (int c = 0; c < 4; c++) begin
        v = pat(f, c);
        if (n == 16) req = "R4 pad";
        else if (n == 24) req = "R5 truncate";
        else if (f == 0) req = "R2 MSB position";
        else if (f == 1) req = "R3 sign order";
        else if (c[0]) req = "R1 channel select";
        else req = "R6 lane mapping";
        check($sformatf("%s n=%0d f=%0d c=%0d", req, n, f, c),
              {4'd0, cap[f][c]}, {4'd0, v[23:4] & m});
      end
  endtask

  initial begin
    run_len(20);
    run_len(16);
    run_len(24);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule